// File: doc/BRIEF.md
# Processor Bus Port with Time-Slot Arbitrated Memory Access

This block connects an asynchronous, non-multiplexed 8-bit processor bus to three on-chip tables. The first is a control register. The second is a connection table split into a low half and a high half. The third is a data table that the processor can only read. The connection and data tables are also used every frame by the time-division switching engine. That engine always has first claim on each table's single port. A processor cycle is therefore parked until the target table has a clock cycle the engine leaves free. Completion is then reported on an acknowledge output.

The bus strobes are brought into the clock domain through synchronizer chains. Address, write data and direction must stay stable while the strobes are active. Address bit 5 low selects the control register; the lower five bits are then don't-care. Address bit 5 high selects channel A4..A0 (0 to 31) of the table chosen by the control register. Because the switching engine touches the data table more often than the connection table, the data-table acknowledge bound is the longer one in practice. The bound is expressed in clock cycles measured from the first free table cycle.

Top module: `cpuport_tdm_arb`

## Requirements
- R1: After reset the acknowledge and read-data enable are low and the control register reads 8'h00.
- R2: With bus_addr[5]=0 the access reaches the control register, bus_addr[4:0] are ignored, and the acknowledge is first seen high in the third clock cycle after the strobes go active.
- R3: For bus_addr[5]=1, control bits [1:0] pick the table: 2'b00 connection low, 2'b01 connection high, 2'b10 or 2'b11 data table; bus_addr[4:0] is the channel.
- R4: Both connection halves are read/write from the bus; a switching-engine read of a channel presents both halves on the cycle after its request.
- R5: The data table is written by the switching engine and its contents are readable from the bus.
- R6: A bus write aimed at the data table is acknowledged but leaves the table unchanged.
- R7: While the engine requests the target table every cycle no acknowledge is given; once it leaves one cycle free the acknowledge is seen high on the second clock after that free cycle.
- R8: With the engine idle, a table access is first acknowledged in the fifth clock cycle after the strobes go active.
- R9: The acknowledge stays high while both strobes remain active, is still high one cycle after release and is low by the third cycle after release.
- R10: Read data is enabled onto the bus only during the acknowledge of a read, never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Chip select, active low, asynchronous |
| bus_stb_n | input | 1 | Data strobe, active low, asynchronous |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Bus address |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data to the processor |
| bus_rdata_en | output | 1 | Drive enable for bus_rdata |
| bus_ack | output | 1 | Data acknowledge, active high |
| tdm_cm_req | input | 1 | Engine claims the connection table this cycle |
| tdm_cm_chan | input | 5 | Engine channel for the connection read |
| tdm_cm_lo | output | 8 | Connection low half read by the engine |
| tdm_cm_hi | output | 8 | Connection high half read by the engine |
| tdm_dm_req | input | 1 | Engine claims the data table this cycle |
| tdm_dm_we | input | 1 | Engine write to the data table |
| tdm_dm_chan | input | 5 | Engine channel for the data table |
| tdm_dm_wdata | input | 8 | Engine write data |
| tdm_dm_rdata | output | 8 | Data table read result for the engine |

## Verification
A corrupted sequencer state shows at once as an acknowledge that arrives at the wrong cycle count. It can also show as an acknowledge that never drops after release, or as one that rises while the engine still holds the table. A wrong latched target or channel shows as read-back mismatches on the very next read of the same location. A wrong control-register value shows in the same way, as can an engine read that returns a stale half. A write leaking into the data table appears at the next bus or engine read of that channel.

// File: rtl/cpuport_pkg.sv
package cpuport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_ACK  = 2'd3
  } cp_state_e;

  typedef enum logic [1:0] {
    TG_CREG = 2'd0,
    TG_CMLO = 2'd1,
    TG_CMHI = 2'd2,
    TG_DMEM = 2'd3
  } cp_tgt_e;
endpackage

// File: rtl/cpuport_sync.sv
module cpuport_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cpuport_ram.sv
module cpuport_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en && we) mem_q[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rdata_q <= '0;
    else if (en && !we)     rdata_q <= mem_q[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cpuport_fsm.sv
module cpuport_fsm
  import cpuport_pkg::*;
#(
  parameter int DAT_W  = 8,
  parameter int ADDR_W = 6,
  localparam int CH_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic [DAT_W-1:0]  wdata,
  input  logic              cm_busy,
  input  logic              dm_busy,
  input  logic [DAT_W-1:0]  cm_lo_rdata,
  input  logic [DAT_W-1:0]  cm_hi_rdata,
  input  logic [DAT_W-1:0]  dm_rdata,
  output cp_state_e         st,
  output cp_tgt_e           tgt,
  output logic [CH_W-1:0]   chan,
  output logic              go,
  output logic              mem_we,
  output logic [DAT_W-1:0]  mem_wdata,
  output logic              ack,
  output logic              rdata_en,
  output logic [DAT_W-1:0]  rdata
);
  cp_state_e        st_q, st_d;
  cp_tgt_e          tgt_q, tgt_in;
  logic [CH_W-1:0]  chan_q;
  logic             rd_q;
  logic [DAT_W-1:0] wd_q, ctrl_q, hold_q, hold_d;
  logic             cap, busy, ctrl_en, hold_en;

  always_comb begin
    if (!addr[ADDR_W-1])  tgt_in = TG_CREG;
    else if (ctrl_q[1])   tgt_in = TG_DMEM;
    else if (ctrl_q[0])   tgt_in = TG_CMHI;
    else                  tgt_in = TG_CMLO;
  end

  assign busy = (tgt_q == TG_DMEM) ? dm_busy : cm_busy;

  always_comb begin
    st_d = st_q;
    cap  = 1'b0;
    go   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (strb_act) begin
        cap  = 1'b1;
        st_d = (tgt_in == TG_CREG) ? ST_ACK : ST_WAIT;
      end
      ST_WAIT: if (!busy) begin
        go   = 1'b1;
        st_d = ST_XFER;
      end
      ST_XFER: st_d = ST_ACK;
      ST_ACK:  if (!strb_act) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ctrl_en = cap && (tgt_in == TG_CREG) && !rd;

  always_comb begin
    hold_en = 1'b0;
    hold_d  = hold_q;
    if (cap && (tgt_in == TG_CREG) && rd) begin
      hold_en = 1'b1;
      hold_d  = ctrl_q;
    end else if (st_q == ST_XFER) begin
      hold_en = 1'b1;
      unique case (tgt_q)
        TG_CMLO: hold_d = cm_lo_rdata;
        TG_CMHI: hold_d = cm_hi_rdata;
        default: hold_d = dm_rdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= TG_CREG;
      chan_q <= '0;
      rd_q   <= 1'b0;
      wd_q   <= '0;
      ctrl_q <= '0;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap) begin
        tgt_q  <= tgt_in;
        chan_q <= addr[CH_W-1:0];
        rd_q   <= rd;
        wd_q   <= wdata;
      end
      if (ctrl_en) ctrl_q <= wdata;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign st        = st_q;
  assign tgt       = tgt_q;
  assign chan      = chan_q;
  assign mem_we    = go && !rd_q && (tgt_q != TG_DMEM);
  assign mem_wdata = wd_q;
  assign ack       = (st_q == ST_ACK);
  assign rdata_en  = ack && rd_q;
  assign rdata     = hold_q;
endmodule

// File: rtl/cpuport_tdm_arb.sv
module cpuport_tdm_arb
  import cpuport_pkg::*;
#(
  parameter int DAT_W       = 8,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = ADDR_W - 1,
  localparam int CH_N       = 2 ** CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_stb_n,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DAT_W-1:0]  bus_wdata,
  output logic [DAT_W-1:0]  bus_rdata,
  output logic              bus_rdata_en,
  output logic              bus_ack,
  input  logic              tdm_cm_req,
  input  logic [CH_W-1:0]   tdm_cm_chan,
  output logic [DAT_W-1:0]  tdm_cm_lo,
  output logic [DAT_W-1:0]  tdm_cm_hi,
  input  logic              tdm_dm_req,
  input  logic              tdm_dm_we,
  input  logic [CH_W-1:0]   tdm_dm_chan,
  input  logic [DAT_W-1:0]  tdm_dm_wdata,
  output logic [DAT_W-1:0]  tdm_dm_rdata
);
  logic             rst_sync_n;
  logic [1:0]       strb_sync;
  logic             strb_act;
  cp_state_e        st;
  cp_tgt_e          tgt;
  logic [CH_W-1:0]  chan;
  logic             go, mem_we;
  logic [DAT_W-1:0] mem_wdata;
  logic [DAT_W-1:0] cm_rdata [2];
  logic             dm_en, dm_we;
  logic [CH_W-1:0]  dm_addr;
  logic [DAT_W-1:0] dm_wdata;

  cpuport_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  cpuport_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_strb_sync (
    .clk(clk), .rst_n(rst_sync_n), .d({bus_sel_n, bus_stb_n}), .q(strb_sync)
  );

  assign strb_act = ~strb_sync[1] & ~strb_sync[0];

  cpuport_fsm #(.DAT_W(DAT_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .strb_act(strb_act),
    .addr(bus_addr), .rd(bus_rd), .wdata(bus_wdata),
    .cm_busy(tdm_cm_req), .dm_busy(tdm_dm_req),
    .cm_lo_rdata(cm_rdata[0]), .cm_hi_rdata(cm_rdata[1]), .dm_rdata(tdm_dm_rdata),
    .st(st), .tgt(tgt), .chan(chan), .go(go),
    .mem_we(mem_we), .mem_wdata(mem_wdata),
    .ack(bus_ack), .rdata_en(bus_rdata_en), .rdata(bus_rdata)
  );

  for (genvar h = 0; h < 2; h++) begin : g_cm
    localparam cp_tgt_e HALF = (h == 0) ? TG_CMLO : TG_CMHI;
    logic            sel;
    logic            en, we;
    logic [CH_W-1:0] addr;
    assign sel  = go && (tgt == HALF);
    assign en   = tdm_cm_req || sel;
    assign we   = !tdm_cm_req && sel && mem_we;
    assign addr = tdm_cm_req ? tdm_cm_chan : chan;
    cpuport_ram #(.DEPTH(CH_N), .WIDTH(DAT_W)) u_ram (
      .clk(clk), .rst_n(rst_sync_n), .en(en), .we(we),
      .addr(addr), .wdata(mem_wdata), .rdata(cm_rdata[h])
    );
  end

  assign tdm_cm_lo = cm_rdata[0];
  assign tdm_cm_hi = cm_rdata[1];

  assign dm_en    = tdm_dm_req || (go && (tgt == TG_DMEM));
  assign dm_we    = tdm_dm_req && tdm_dm_we;
  assign dm_addr  = tdm_dm_req ? tdm_dm_chan : chan;
  assign dm_wdata = tdm_dm_wdata;

  cpuport_ram #(.DEPTH(CH_N), .WIDTH(DAT_W)) u_dm (
    .clk(clk), .rst_n(rst_sync_n), .en(dm_en), .we(dm_we),
    .addr(dm_addr), .wdata(dm_wdata), .rdata(tdm_dm_rdata)
  );
endmodule

// File: rtl/cpuport_chk.sv
module cpuport_chk
  import cpuport_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      strb_act,
  input cp_state_e st,
  input cp_tgt_e   tgt,
  input logic      ack,
  input logic      rdata_en,
  input logic      addr_msb,
  input logic      dm_we,
  input logic      tdm_dm_req,
  input logic      tdm_dm_we,
  input logic      tdm_cm_req
);
  AST_CREG_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && strb_act && !addr_msb) |=> ack); // R2
  AST_DM_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> (tdm_dm_req && tdm_dm_we)); // R6
  AST_CM_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && tgt != TG_DMEM && tdm_cm_req) |=> (st == ST_WAIT)); // R7
  AST_DM_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && tgt == TG_DMEM && tdm_dm_req) |=> (st == ST_WAIT)); // R7
  AST_FREE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && tgt == TG_DMEM && !tdm_dm_req) |=> (st == ST_XFER)); // R7
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> strb_act); // R9
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && strb_act) |=> ack); // R9
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !strb_act) |=> !ack); // R9
  AST_RDEN_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_en |-> ack); // R10
endmodule

bind cpuport_tdm_arb cpuport_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .strb_act(strb_act), .st(st), .tgt(tgt),
  .ack(bus_ack), .rdata_en(bus_rdata_en), .addr_msb(bus_addr[5]),
  .dm_we(dm_we), .tdm_dm_req(tdm_dm_req), .tdm_dm_we(tdm_dm_we),
  .tdm_cm_req(tdm_cm_req)
);

// File: tb/cpuport_tdm_arb_bench.sv
module cpuport_tdm_arb_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel_n = 1'b1, bus_stb_n = 1'b1, bus_rd = 1'b1;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rdata_en, bus_ack;
  logic       tdm_cm_req = 1'b0;
  logic [4:0] tdm_cm_chan = '0;
  logic [7:0] tdm_cm_lo, tdm_cm_hi;
  logic       tdm_dm_req = 1'b0, tdm_dm_we = 1'b0;
  logic [4:0] tdm_dm_chan = '0;
  logic [7:0] tdm_dm_wdata = '0;
  logic [7:0] tdm_dm_rdata;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cpuport_tdm_arb u_cpuport_tdm_arb (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_stb_n(bus_stb_n),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_en(bus_rdata_en), .bus_ack(bus_ack),
    .tdm_cm_req(tdm_cm_req), .tdm_cm_chan(tdm_cm_chan),
    .tdm_cm_lo(tdm_cm_lo), .tdm_cm_hi(tdm_cm_hi),
    .tdm_dm_req(tdm_dm_req), .tdm_dm_we(tdm_dm_we), .tdm_dm_chan(tdm_dm_chan),
    .tdm_dm_wdata(tdm_dm_wdata), .tdm_dm_rdata(tdm_dm_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start(input bit rd, input logic [5:0] a, input logic [7:0] wd);
    @(negedge clk);
    bus_rd = rd; bus_addr = a; bus_wdata = wd;
    bus_sel_n = 1'b0; bus_stb_n = 1'b0;
  endtask

  task automatic bus_end(input string req);
    bit h1, h3;
    @(negedge clk);
    bus_sel_n = 1'b1; bus_stb_n = 1'b1;
    @(negedge clk); h1 = bus_ack;
    @(negedge clk);
    @(negedge clk); h3 = bus_ack;
    check(h1 && !h3, req, {h1, h3}, 2'b10);
  endtask

  // lat < 0: latency not checked
  task automatic access(input bit rd, input logic [5:0] a, input logic [7:0] wd,
                        input int lat, input string req, output logic [7:0] rdat);
    int cnt = 0;
    bus_start(rd, a, wd);
    while (!bus_ack && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    if (lat >= 0) check(cnt == lat, req, cnt, lat);
    else          check(bus_ack, req, bus_ack, 1);
    check(bus_rdata_en == rd, "R10 rdata_en during ack", bus_rdata_en, rd);
    rdat = bus_rdata;
    bus_end("R9 ack hold/release");
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check(!bus_ack && !bus_rdata_en, "R1 idle outputs", {bus_ack, bus_rdata_en}, 0);
    access(1'b1, 6'h00, 8'h00, 3, "R2 creg latency", r);
    check(r == 8'h00, "R1 creg reset value", r, 8'h00);
  endtask

  task automatic t_creg();
    logic [7:0] r;
    access(1'b0, 6'h1F, 8'h5C, 3, "R2 creg write latency", r);
    access(1'b1, 6'h0B, 8'h00, 3, "R2 creg read latency", r);
    check(r == 8'h5C, "R2 low bits ignored", r, 8'h5C);
    access(1'b0, 6'h00, 8'h00, 3, "R2 creg clear", r);
  endtask

  task automatic t_cm();
    logic [7:0] r;
    access(1'b0, 6'h23, 8'h3C, 5, "R8 cm low write latency", r);
    access(1'b0, 6'h3F, 8'hE1, 5, "R8 cm low ch31 write", r);
    access(1'b0, 6'h00, 8'h01, 3, "R3 select high", r);
    access(1'b0, 6'h23, 8'h96, 5, "R4 cm high write", r);
    access(1'b1, 6'h23, 8'h00, 5, "R8 cm high read latency", r);
    check(r == 8'h96, "R4 cm high readback", r, 8'h96);
    access(1'b0, 6'h00, 8'h00, 3, "R3 select low", r);
    access(1'b1, 6'h23, 8'h00, 5, "R4 cm low read", r);
    check(r == 8'h3C, "R3 cm low readback", r, 8'h3C);
    access(1'b1, 6'h3F, 8'h00, 5, "R4 cm low ch31 read", r);
    check(r == 8'hE1, "R4 cm low ch31 readback", r, 8'hE1);
    @(negedge clk);
    tdm_cm_req = 1'b1; tdm_cm_chan = 5'd3;
    @(negedge clk);
    tdm_cm_req = 1'b0;
    check(tdm_cm_lo == 8'h3C && tdm_cm_hi == 8'h96, "R4 engine read both halves",
          {tdm_cm_hi, tdm_cm_lo}, 16'h963C);
  endtask

  task automatic t_dm();
    logic [7:0] r;
    @(negedge clk);
    tdm_dm_req = 1'b1; tdm_dm_we = 1'b1; tdm_dm_chan = 5'd7; tdm_dm_wdata = 8'h77;
    @(negedge clk);
    tdm_dm_req = 1'b0; tdm_dm_we = 1'b0;
    access(1'b0, 6'h00, 8'h02, 3, "R3 select data table", r);
    access(1'b1, 6'h27, 8'h00, 5, "R5 data read latency", r);
    check(r == 8'h77, "R5 data table readback", r, 8'h77);
    access(1'b0, 6'h27, 8'h00, 5, "R6 data write acknowledged", r);
    access(1'b1, 6'h27, 8'h00, 5, "R6 read after write", r);
    check(r == 8'h77, "R6 data table unchanged", r, 8'h77);
    access(1'b0, 6'h00, 8'h03, 3, "R3 select 2'b11", r);
    access(1'b1, 6'h27, 8'h00, 5, "R3 2'b11 read", r);
    check(r == 8'h77, "R3 2'b11 reaches data table", r, 8'h77);
    @(negedge clk);
    tdm_dm_req = 1'b1; tdm_dm_chan = 5'd7;
    @(negedge clk);
    tdm_dm_req = 1'b0;
    check(tdm_dm_rdata == 8'h77, "R6 engine sees unchanged data", tdm_dm_rdata, 8'h77);
  endtask

  task automatic t_prio(input bit dm);
    logic [7:0] r;
    int early = 0;
    bit a1, a2;
    access(1'b0, 6'h00, dm ? 8'h02 : 8'h00, 3, "R3 select for priority", r);
    @(negedge clk);
    if (dm) tdm_dm_req = 1'b1; else tdm_cm_req = 1'b1;
    tdm_dm_chan = 5'd0; tdm_cm_chan = 5'd0;
    bus_start(dm, 6'h25, 8'h55);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_ack) early++;
    end
    check(early == 0, "R7 no ack while engine holds table", early, 0);
    tdm_dm_req = 1'b0; tdm_cm_req = 1'b0;
    @(negedge clk); a1 = bus_ack;
    @(negedge clk); a2 = bus_ack;
    check(!a1 && a2, "R7 ack two cycles after free slot", {a1, a2}, 2'b01);
    bus_end("R9 release after priority wait");
    if (!dm) begin
      access(1'b1, 6'h25, 8'h00, 5, "R7 readback after wait", r);
      check(r == 8'h55, "R7 delayed write landed", r, 8'h55);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_creg();
    t_cm();
    t_dm();
    t_prio(1'b0);
    t_prio(1'b1);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule